// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block encrypts one 128-bit plaintext block under a 128-bit cipher key. It uses a single round datapath that is reused over the whole cipher. When an operation is accepted, the plaintext is XORed with the cipher key and loaded into a 128-bit state register. Each of the next ten clock cycles then applies one full round to that register: byte substitution, the row rotation, column mixing (skipped in the tenth round) and the round-key XOR. The round key for each round is derived in the same cycle from the previous round key, so no expanded-key storage exists.

Operands are offered with `start_valid` and accepted on any clock edge where `start_ready` is high. The ciphertext appears on `cipher_out` together with a one-cycle `done` pulse. The result stays on `cipher_out` until the next operation is accepted. The block is ready again in the same cycle as `done`, so operations can run back to back with no gap cycle.

Top module: `aes128_iter_core`

## Requirements
- R1: After reset, `start_ready` is 1 and `done` is 0.
- R2: An operation is accepted on a rising edge where `start_valid` and `start_ready` are both 1. `start_ready` is then 0 for the following ten cycles and returns to 1 in the cycle where `done` is high.
- R3: `done` is high for exactly one cycle per accepted operation, and that cycle begins at the tenth rising edge after the accepting edge.
- R4: For key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the result is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: Blocks are column-major: bits [127:120] are byte 0 at row 0, column 0, and bits [95:88] are byte 4 at row 0, column 1. Key 2b7e151628aed2a6abf7158809cf4f3c with plaintext 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32.
- R6: While `start_ready` is 0, `start_valid`, `plain_in` and `key_in` have no effect on the running operation or its result.
- R7: For arbitrary key and plaintext, `cipher_out` in the `done` cycle equals standard AES-128 encryption. That is: an initial key XOR, nine full rounds, and a final round without column mixing.
- R8: A start offered in the `done` cycle is accepted. Back-to-back operations then produce `done` pulses exactly 11 cycles apart.
- R9: While idle, `cipher_out` keeps the last ciphertext until a new operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request to begin an encryption |
| start_ready | output | 1 | High when a request can be accepted |
| plain_in | input | 128 | Plaintext block, column-major |
| key_in | input | 128 | Cipher key, column-major |
| done | output | 1 | One-cycle pulse: ciphertext valid |
| cipher_out | output | 128 | Ciphertext block |

## Verification
The bench drives two published vectors whose byte layouts expose any transposed row/column mapping or reversed byte order. A wrong layout would produce a totally different ciphertext. A bench reference model runs in parallel on random vectors and would catch a last round that still mixes columns, a wrong round-constant sequence, or an off-by-one round count, because each of these corrupts every output. Operands toggled during a busy period catch a design that recaptures them mid-operation. Continuous back-to-back requests catch a design that needs an idle cycle after `done`, because the `done` spacing then grows past 11.

// File: rtl/aes128_pkg.sv
package aes128_pkg;

    localparam int NUM_ROUNDS = 10;
    localparam int ROUND_W    = $clog2(NUM_ROUNDS + 1);
    localparam int BLOCK_W    = 128;
    localparam int NB         = 4;

    typedef logic [7:0]         byte_t;
    typedef logic [BLOCK_W-1:0] block_t;

    // MSB bit index of the byte at (row, col), column-major.
    function automatic int byte_msb(int row, int col);
        return BLOCK_W - 1 - 8 * (col * NB + row);
    endfunction

    function automatic byte_t xtime(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc;
        byte_t p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xtime(p);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254 (0 maps to 0).
    function automatic byte_t gf_inv(byte_t a);
        byte_t r;
        byte_t p;
        r = 8'h01;
        p = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic byte_t sbox(byte_t a);
        byte_t b;
        b = gf_inv(a);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes128_sub_shift.sv
module aes128_sub_shift
    import aes128_pkg::*;
(
    input  block_t state_in,
    output block_t state_out
);
    // Substitution with the row rotation folded into the wiring:
    // output (r,c) takes input (r, (c+r) mod NB).
    for (genvar r = 0; r < NB; r++) begin : g_row
        for (genvar c = 0; c < NB; c++) begin : g_col
            localparam int DST = byte_msb(r, c);
            localparam int SRC = byte_msb(r, (c + r) % NB);
            assign state_out[DST -: 8] = sbox(state_in[SRC -: 8]);
        end
    end
endmodule

// File: rtl/aes128_mix_cols.sv
module aes128_mix_cols
    import aes128_pkg::*;
(
    input  block_t state_in,
    output block_t state_out
);
    for (genvar c = 0; c < NB; c++) begin : g_col
        byte_t a0, a1, a2, a3;
        byte_t d0, d1, d2, d3;
        assign a0 = state_in[byte_msb(0, c) -: 8];
        assign a1 = state_in[byte_msb(1, c) -: 8];
        assign a2 = state_in[byte_msb(2, c) -: 8];
        assign a3 = state_in[byte_msb(3, c) -: 8];
        assign d0 = xtime(a0);
        assign d1 = xtime(a1);
        assign d2 = xtime(a2);
        assign d3 = xtime(a3);
        assign state_out[byte_msb(0, c) -: 8] = d0 ^ d1 ^ a1 ^ a2 ^ a3;
        assign state_out[byte_msb(1, c) -: 8] = a0 ^ d1 ^ d2 ^ a2 ^ a3;
        assign state_out[byte_msb(2, c) -: 8] = a0 ^ a1 ^ d2 ^ d3 ^ a3;
        assign state_out[byte_msb(3, c) -: 8] = d0 ^ a0 ^ a1 ^ a2 ^ d3;
    end
endmodule

// File: rtl/aes128_key_step.sv
module aes128_key_step
    import aes128_pkg::*;
(
    input  block_t key_in,
    input  byte_t  rcon,
    output block_t key_out
);
    logic [31:0] w0, w1, w2, w3;
    logic [31:0] g;
    logic [31:0] n0, n1, n2, n3;

    assign w0 = key_in[127:96];
    assign w1 = key_in[95:64];
    assign w2 = key_in[63:32];
    assign w3 = key_in[31:0];

    // Rotate the last word by one byte, substitute, add round constant.
    assign g = {sbox(w3[23:16]) ^ rcon, sbox(w3[15:8]), sbox(w3[7:0]), sbox(w3[31:24])};

    assign n0 = w0 ^ g;
    assign n1 = w1 ^ n0;
    assign n2 = w2 ^ n1;
    assign n3 = w3 ^ n2;

    assign key_out = {n0, n1, n2, n3};
endmodule

// File: rtl/aes128_iter_core.sv
module aes128_iter_core
    import aes128_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_valid,
    output logic         start_ready,
    input  logic [127:0] plain_in,
    input  logic [127:0] key_in,
    output logic         done,
    output logic [127:0] cipher_out
);
    typedef struct packed {
        logic               busy;
        logic               done;
        logic [ROUND_W-1:0] rnd;
        byte_t              rcon;
        block_t             state;
        block_t             rkey;
    } core_t;

    core_t  ctl_d, ctl_q;
    block_t shifted, mixed, key_next;
    logic   last_round;
    logic   accept;

    aes128_sub_shift u_sub_shift (
        .state_in  (ctl_q.state),
        .state_out (shifted)
    );

    aes128_mix_cols u_mix (
        .state_in  (shifted),
        .state_out (mixed)
    );

    aes128_key_step u_key (
        .key_in  (ctl_q.rkey),
        .rcon    (ctl_q.rcon),
        .key_out (key_next)
    );

    assign last_round = (ctl_q.rnd == ROUND_W'(NUM_ROUNDS));
    assign accept     = start_valid && !ctl_q.busy;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (ctl_q.busy) begin
            ctl_d.rkey  = key_next;
            ctl_d.state = (last_round ? shifted : mixed) ^ key_next;
            ctl_d.rcon  = xtime(ctl_q.rcon);
            ctl_d.rnd   = ctl_q.rnd + ROUND_W'(1);
            if (last_round) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end else if (accept) begin
            ctl_d.busy  = 1'b1;
            ctl_d.rnd   = ROUND_W'(1);
            ctl_d.rcon  = 8'h01;
            ctl_d.state = plain_in ^ key_in;
            ctl_d.rkey  = key_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign start_ready = !ctl_q.busy;
    assign done        = ctl_q.done;
    assign cipher_out  = ctl_q.state;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R3
    AST_READY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> start_ready);  // R2
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready) |=> !start_ready);  // R2
    AST_ROUND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_ready |-> (ctl_q.rnd >= ROUND_W'(1) && ctl_q.rnd <= ROUND_W'(NUM_ROUNDS)));  // R2
    AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ready && !start_valid) |=> $stable(cipher_out));  // R9
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ready && !last_round) |=> !start_ready);  // R6

endmodule

// File: tb/sim_aes128_iter_core.sv
module sim_aes128_iter_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_valid = 1'b0;
    logic         start_ready;
    logic [127:0] plain_in = '0;
    logic [127:0] key_in = '0;
    logic         done;
    logic [127:0] cipher_out;

    always #10 clk = ~clk;  // 50 MHz

    aes128_iter_core u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (start_valid),
        .start_ready (start_ready),
        .plain_in    (plain_in),
        .key_in      (key_in),
        .done        (done),
        .cipher_out  (cipher_out)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit run_checks = 1'b0;

    task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural AES reference ----------------
    logic [7:0] tsbox [256];

    function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
        int x, y, r;
        x = a; y = b; r = 0;
        while (y != 0) begin
            if (y & 1) r = r ^ x;
            x = x << 1;
            if (x & 256) x = x ^ 'h11b;
            y = y >> 1;
        end
        return r[7:0];
    endfunction

    function automatic logic [7:0] bsub(logic [7:0] x);
        logic [7:0] inv, s;
        inv = 8'h00;
        for (int y = 1; y < 256; y++)
            if (x != 0 && bmul(x, y[7:0]) == 8'h01) inv = y[7:0];
        s = 8'h63;
        for (int i = 0; i < 8; i++)
            s[i] = s[i] ^ inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
        return s;
    endfunction

    function automatic logic [127:0] ref_encrypt(logic [127:0] pt, logic [127:0] k);
        logic [31:0] w [44];
        logic [7:0]  s [16];
        logic [7:0]  t [16];
        logic [31:0] tmp;
        logic [7:0]  rc;
        logic [127:0] res;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = k[127 - 32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {tsbox[tmp[23:16]] ^ rc, tsbox[tmp[15:8]], tsbox[tmp[7:0]], tsbox[tmp[31:24]]};
                rc = bmul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int i = 0; i < 16; i++) s[i] = pt[127 - 8*i -: 8] ^ w[i/4][31 - 8*(i%4) -: 8];
        for (int rnd = 1; rnd <= 10; rnd++) begin
            for (int i = 0; i < 16; i++) s[i] = tsbox[s[i]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) t[c*4 + r] = s[((c + r) % 4)*4 + r];
            for (int c = 0; c < 4; c++) begin
                if (rnd != 10) begin
                    s[c*4+0] = bmul(t[c*4+0],2) ^ bmul(t[c*4+1],3) ^ t[c*4+2] ^ t[c*4+3];
                    s[c*4+1] = t[c*4+0] ^ bmul(t[c*4+1],2) ^ bmul(t[c*4+2],3) ^ t[c*4+3];
                    s[c*4+2] = t[c*4+0] ^ t[c*4+1] ^ bmul(t[c*4+2],2) ^ bmul(t[c*4+3],3);
                    s[c*4+3] = bmul(t[c*4+0],3) ^ t[c*4+1] ^ t[c*4+2] ^ bmul(t[c*4+3],2);
                end else begin
                    for (int r = 0; r < 4; r++) s[c*4+r] = t[c*4+r];
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4*rnd + i/4][31 - 8*(i%4) -: 8];
        end
        for (int i = 0; i < 16; i++) res[127 - 8*i -: 8] = s[i];
        return res;
    endfunction

    // ---------------- cycle model ----------------
    int           m_left = 0;
    bit           m_done = 1'b0;
    bit           m_have = 1'b0;
    logic [127:0] m_pend = '0;
    logic [127:0] m_ct   = '0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_left = 0; m_done = 1'b0; m_have = 1'b0;
        end else begin
            m_done = 1'b0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    m_done = 1'b1; m_have = 1'b1; m_ct = m_pend;
                end
            end else if (start_valid) begin
                m_left = 10;
                m_pend = ref_encrypt(plain_in, key_in);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_checks) begin
            chk(start_ready == (m_left == 0), "R2 ready", {127'b0, start_ready}, {127'b0, (m_left == 0)});
            chk(done == m_done, "R3 done", {127'b0, done}, {127'b0, m_done});
            if (m_done)
                chk(cipher_out == m_ct, "R7 ciphertext", cipher_out, m_ct);
            else if (m_left == 0 && m_have)
                chk(cipher_out == m_ct, "R9 hold", cipher_out, m_ct);
        end
    end

    task automatic wait_done(output int at);
        at = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done) begin at = cyc; break; end
        end
    endtask

    task automatic one_shot(logic [127:0] k, logic [127:0] p, logic [127:0] exp, string tag);
        int at;
        @(negedge clk);
        key_in = k; plain_in = p; start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        wait_done(at);
        chk(done && cipher_out == exp, tag, cipher_out, exp);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int at, prev;
        for (int i = 0; i < 256; i++) tsbox[i] = bsub(i[7:0]);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_ready == 1'b1, "R1 ready after reset", {127'b0, start_ready}, 128'd1);
        chk(done == 1'b0, "R1 done after reset", {127'b0, done}, 128'd0);
        run_checks = 1'b1;

        // R4: standard example vector
        one_shot(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
                 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 known vector");
        // R5: byte layout vector
        one_shot(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
                 128'h3925841d02dc09fbdc118597196a0b32, "R5 byte order");
        repeat (3) @(negedge clk);
        chk(cipher_out == 128'h3925841d02dc09fbdc118597196a0b32, "R9 idle hold",
            cipher_out, 128'h3925841d02dc09fbdc118597196a0b32);

        // R6: operands toggled while busy
        @(negedge clk);
        key_in = 128'h000102030405060708090a0b0c0d0e0f;
        plain_in = 128'h00112233445566778899aabbccddeeff;
        start_valid = 1'b1;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            key_in = {$urandom, $urandom, $urandom, $urandom};
            plain_in = {$urandom, $urandom, $urandom, $urandom};
        end
        start_valid = 1'b0;
        wait_done(at);
        chk(cipher_out == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R6 busy ignore",
            cipher_out, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

        // R7: random vectors with idle gaps
        for (int n = 0; n < 8; n++) begin
            logic [127:0] k, p;
            k = {$urandom, $urandom, $urandom, $urandom};
            p = {$urandom, $urandom, $urandom, $urandom};
            one_shot(k, p, ref_encrypt(p, k), "R7 random");
            repeat (n % 3) @(negedge clk);
        end

        // R8: back-to-back requests
        @(negedge clk);
        key_in = {$urandom, $urandom, $urandom, $urandom};
        plain_in = {$urandom, $urandom, $urandom, $urandom};
        start_valid = 1'b1;
        prev = -1;
        for (int n = 0; n < 6; n++) begin
            wait_done(at);
            if (prev >= 0)
                chk(at - prev == 11, "R8 done spacing", at - prev, 128'd11);
            prev = at;
            key_in = {$urandom, $urandom, $urandom, $urandom};
            plain_in = {$urandom, $urandom, $urandom, $urandom};
            if (n == 5) start_valid = 1'b0;
        end

        repeat (5) @(negedge clk);
        run_checks = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule